// File: doc/BRIEF.md
# Dual-Port Banked ECC Data Array

This block is the data storage behind a first-level data cache that serves two memory requests every cycle. The 128-bit words are spread over eight banks, chosen by physical address bits [6:4]. Each port presents a 40-bit physical address, a 3-bit size, a load/store flag, 128 bits of write data, 16 byte strobes and an 8-bit tag. One cycle later the port returns read data, the echoed tag, an acknowledge, a replay flag and an uncorrectable-error flag. The array always hits: tag lookup, coherence and refills sit elsewhere. Only the bank and row fields of the address and the strobes steer the array. The size field travels with the request and has no effect here.

Every stored word carries single-error-correct, double-error-detect check bits. Loads return corrected data. An uncorrectable word is reported with a replay so the requester can retry or escalate. When both ports aim at the same bank in one cycle, port 0 wins and port 1 is told to replay. The losing request neither reads nor writes the array. Stores read the old word, merge the strobed bytes over its corrected value and write a freshly encoded word.

Each port has a response state register. Its states are RSP_IDLE (no response), RSP_LOAD (load acknowledged with data), RSP_STORE (store acknowledged), RSP_RETRY (lost the bank to port 0) and RSP_POISON (double-bit error, replay). The register is loaded every cycle from the request in front of it:
- no valid request goes to RSP_IDLE;
- a valid request without the bank goes to RSP_RETRY;
- a granted store goes to RSP_STORE;
- a granted load whose word fails detection goes to RSP_POISON;
- any other granted load goes to RSP_LOAD.

A test-only hook flips chosen bits of one stored codeword.

Top module: `l1d_dual_port_array`

## Requirements
- R1: After reset every response output is low and every entry reads back as an all-zero word with no error indication.
- R2: A valid load's response comes in the next cycle, with ack=1 and replay=0. It returns the 128-bit word held at bank paddr[6:4] and row paddr[10:7], and the request tag. Other address bits are ignored.
- R3: If both ports are valid with equal paddr[6:4], port 0 is served. Port 1 answers next cycle with replay=1 and ack=0 and its tag. Its store is not written.
- R4: Requests to different banks are both served in the same cycle.
- R5: A store writes byte i (bits 8i+7:8i) only when wstrb[i]=1. It answers next cycle with ack=1 and all-zero read data.
- R6: A load of a word with one flipped bit returns the corrected data with ack=1 and replay=0. It raises that port's bit of ecc_corr_pulse for exactly one cycle.
- R7: A load of a word with two flipped bits returns uncorrectable=1, replay=1, ack=0 and zero data. It raises that port's bit of ecc_uncorr_pulse.
- R8: A cycle without a valid request on a port gives ack, replay, uncorrectable and both pulse bits low for that port in the next cycle.
- R9: A store merges over the corrected old word and re-encodes all check bits. A later load of that word shows no correction pulse.
- R10: The flip hook XORs tst_flip_mask into the codeword at bank tst_flip_bank, row tst_flip_row on a clock edge where tst_flip_en=1. The codeword layout is as follows. Bit j (j<136) holds Hamming position j+1. Check bits sit at the power-of-two positions. Data bits fill the other positions in ascending order, so data bit 0 is codeword bit 2 and data bit 1 is codeword bit 4. Bit 136 is overall parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| p0_vld | input | 1 | Port 0 request valid |
| p0_paddr | input | 40 | Port 0 physical address |
| p0_size | input | 3 | Port 0 access size (carried, not used) |
| p0_is_load | input | 1 | Port 0 load (1) or store (0) |
| p0_wdata | input | 128 | Port 0 store data |
| p0_wstrb | input | 16 | Port 0 byte strobes |
| p0_tag | input | 8 | Port 0 request tag |
| p1_vld | input | 1 | Port 1 request valid |
| p1_paddr | input | 40 | Port 1 physical address |
| p1_size | input | 3 | Port 1 access size (carried, not used) |
| p1_is_load | input | 1 | Port 1 load (1) or store (0) |
| p1_wdata | input | 128 | Port 1 store data |
| p1_wstrb | input | 16 | Port 1 byte strobes |
| p1_tag | input | 8 | Port 1 request tag |
| p0_rdata | output | 128 | Port 0 load data |
| p0_rtag | output | 8 | Port 0 echoed tag |
| p0_ack | output | 1 | Port 0 request completed |
| p0_replay | output | 1 | Port 0 must retry |
| p0_uncorr | output | 1 | Port 0 uncorrectable data |
| p1_rdata | output | 128 | Port 1 load data |
| p1_rtag | output | 8 | Port 1 echoed tag |
| p1_ack | output | 1 | Port 1 request completed |
| p1_replay | output | 1 | Port 1 must retry |
| p1_uncorr | output | 1 | Port 1 uncorrectable data |
| ecc_corr_pulse | output | 2 | Per-port single-bit correction event |
| ecc_uncorr_pulse | output | 2 | Per-port double-bit detection event |
| tst_flip_en | input | 1 | Test hook: apply flip mask |
| tst_flip_bank | input | 3 | Test hook: target bank |
| tst_flip_row | input | 4 | Test hook: target row |
| tst_flip_mask | input | 137 | Test hook: codeword bits to invert |

## Verification
The bound checker watches the following on every cycle:
- the arbitration outcome, meaning a same-bank pair always turns into a port 1 replay and port 0 is never blocked;
- tag echo one cycle later;
- zero data and an acknowledge on store responses;
- silence after idle cycles;
- the fixed relations among the uncorrectable flag, the replay and the pulses.

Only the bench scenarios can show that the stored contents are right. That covers byte-strobe merging, that a replayed store left its word untouched, that corrected data equals what was written, and that a store over a damaged word writes clean check bits.

// File: rtl/dca_pkg.sv
package dca_pkg;
    localparam int DATA_W   = 128;
    localparam int STRB_W   = DATA_W / 8;
    localparam int CHK_W    = 8;
    localparam int HAM_N    = DATA_W + CHK_W;
    localparam int CW_W     = HAM_N + 1;
    localparam int PA_W     = 40;
    localparam int TAG_W    = 8;
    localparam int SIZE_W   = 3;
    localparam int BANK_LSB = 4;

    typedef enum logic [2:0] {
        RSP_IDLE,
        RSP_LOAD,
        RSP_STORE,
        RSP_RETRY,
        RSP_POISON
    } rsp_state_e;

    // Hamming positions 1..HAM_N sit at codeword bits 0..HAM_N-1, overall parity on top.
    function automatic logic [CW_W-1:0] ecc_encode(input logic [DATA_W-1:0] d);
        logic [HAM_N:1]   h;
        logic [CHK_W-1:0] s;
        int               k;
        h = '0;
        s = '0;
        k = 0;
        for (int p = 1; p <= HAM_N; p++) begin
            if ((p & (p - 1)) != 0) begin
                h[p] = d[k];
                k++;
            end
        end
        for (int p = 1; p <= HAM_N; p++) begin
            if (h[p]) s ^= CHK_W'(p);
        end
        for (int i = 0; i < CHK_W; i++) begin
            h[1 << i] = s[i];
        end
        return {^h, h};
    endfunction

    function automatic logic [DATA_W-1:0] byte_merge(input logic [DATA_W-1:0] old_w,
                                                     input logic [DATA_W-1:0] new_w,
                                                     input logic [STRB_W-1:0] strb);
        logic [DATA_W-1:0] r;
        r = old_w;
        for (int i = 0; i < STRB_W; i++) begin
            if (strb[i]) r[8*i +: 8] = new_w[8*i +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/dca_ecc_dec.sv
module dca_ecc_dec
    import dca_pkg::*;
(
    input  logic [CW_W-1:0]   cw,
    output logic [DATA_W-1:0] data,
    output logic              sec,
    output logic              ded
);
    always_comb begin
        logic [HAM_N:1]   h;
        logic [HAM_N:1]   fix;
        logic [CHK_W-1:0] syn;
        logic             par;
        int               k;
        h   = cw[HAM_N-1:0];
        syn = '0;
        for (int p = 1; p <= HAM_N; p++) begin
            if (h[p]) syn ^= CHK_W'(p);
        end
        par = ^cw;
        fix = h;
        sec = 1'b0;
        ded = 1'b0;
        if (par) begin
            if (syn == '0) begin
                sec = 1'b1;
            end else if (int'(syn) <= HAM_N) begin
                for (int p = 1; p <= HAM_N; p++) begin
                    if (p == int'(syn)) fix[p] = ~fix[p];
                end
                sec = 1'b1;
            end else begin
                ded = 1'b1;
            end
        end else if (syn != '0) begin
            ded = 1'b1;
        end
        data = '0;
        k    = 0;
        for (int p = 1; p <= HAM_N; p++) begin
            if ((p & (p - 1)) != 0) begin
                data[k] = fix[p];
                k++;
            end
        end
    end
endmodule

// File: rtl/dca_bank.sv
module dca_bank #(
    parameter  int ROWS  = 16,
    parameter  int CW_W  = 137,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] rrow,
    output logic [CW_W-1:0]  rcw,
    input  logic             we,
    input  logic [ROW_W-1:0] wrow,
    input  logic [CW_W-1:0]  wcw,
    input  logic             flip_en,
    input  logic [ROW_W-1:0] flip_row,
    input  logic [CW_W-1:0]  flip_mask
);
    logic [CW_W-1:0] mem [ROWS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem[r] <= '0;
        end else begin
            if (flip_en) mem[flip_row] <= mem[flip_row] ^ flip_mask;
            if (we)      mem[wrow]     <= wcw;
        end
    end

    assign rcw = mem[rrow];
endmodule

// File: rtl/dca_port_rsp.sv
module dca_port_rsp
    import dca_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic              req_grant,
    input  logic              req_load,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [DATA_W-1:0] dec_data,
    input  logic              dec_sec,
    input  logic              dec_ded,
    output logic [DATA_W-1:0] rsp_data,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              rsp_ack,
    output logic              rsp_replay,
    output logic              rsp_poison,
    output logic              corr_evt,
    output logic              uncorr_evt
);
    rsp_state_e state, state_nx;

    always_comb begin
        if (!req_vld)        state_nx = RSP_IDLE;
        else if (!req_grant) state_nx = RSP_RETRY;
        else if (!req_load)  state_nx = RSP_STORE;
        else if (dec_ded)    state_nx = RSP_POISON;
        else                 state_nx = RSP_LOAD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RSP_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_data <= '0;
            rsp_tag  <= '0;
            corr_evt <= 1'b0;
        end else begin
            rsp_data <= (state_nx == RSP_LOAD) ? dec_data : '0;
            rsp_tag  <= req_vld ? req_tag : '0;
            corr_evt <= (state_nx == RSP_LOAD) && dec_sec;
        end
    end

    always_comb begin
        rsp_ack    = 1'b0;
        rsp_replay = 1'b0;
        rsp_poison = 1'b0;
        uncorr_evt = 1'b0;
        unique case (state)
            RSP_IDLE:   ;
            RSP_LOAD:   rsp_ack = 1'b1;
            RSP_STORE:  rsp_ack = 1'b1;
            RSP_RETRY:  rsp_replay = 1'b1;
            RSP_POISON: begin
                rsp_replay = 1'b1;
                rsp_poison = 1'b1;
                uncorr_evt = 1'b1;
            end
            default:    ;
        endcase
    end
endmodule

// File: rtl/l1d_dual_port_array.sv
module l1d_dual_port_array
    import dca_pkg::*;
#(
    parameter  int NBANKS  = 8,
    parameter  int ROWS    = 16,
    localparam int BANK_W  = $clog2(NBANKS),
    localparam int ROW_W   = $clog2(ROWS),
    localparam int ROW_LSB = BANK_LSB + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p0_vld,
    input  logic [PA_W-1:0]   p0_paddr,
    input  logic [SIZE_W-1:0] p0_size,
    input  logic              p0_is_load,
    input  logic [DATA_W-1:0] p0_wdata,
    input  logic [STRB_W-1:0] p0_wstrb,
    input  logic [TAG_W-1:0]  p0_tag,
    input  logic              p1_vld,
    input  logic [PA_W-1:0]   p1_paddr,
    input  logic [SIZE_W-1:0] p1_size,
    input  logic              p1_is_load,
    input  logic [DATA_W-1:0] p1_wdata,
    input  logic [STRB_W-1:0] p1_wstrb,
    input  logic [TAG_W-1:0]  p1_tag,
    output logic [DATA_W-1:0] p0_rdata,
    output logic [TAG_W-1:0]  p0_rtag,
    output logic              p0_ack,
    output logic              p0_replay,
    output logic              p0_uncorr,
    output logic [DATA_W-1:0] p1_rdata,
    output logic [TAG_W-1:0]  p1_rtag,
    output logic              p1_ack,
    output logic              p1_replay,
    output logic              p1_uncorr,
    output logic [1:0]        ecc_corr_pulse,
    output logic [1:0]        ecc_uncorr_pulse,
    input  logic              tst_flip_en,
    input  logic [BANK_W-1:0] tst_flip_bank,
    input  logic [ROW_W-1:0]  tst_flip_row,
    input  logic [CW_W-1:0]   tst_flip_mask
);
    localparam int NPORTS = 2;

    logic [NPORTS-1:0] vld, ld, grant, sec, ded, ack, rep, poison;
    logic [PA_W-1:0]   pa     [NPORTS];
    logic [DATA_W-1:0] wdata  [NPORTS];
    logic [STRB_W-1:0] wstrb  [NPORTS];
    logic [TAG_W-1:0]  tag    [NPORTS];
    logic [TAG_W-1:0]  rtag   [NPORTS];
    logic [BANK_W-1:0] bnk    [NPORTS];
    logic [ROW_W-1:0]  row    [NPORTS];
    logic [CW_W-1:0]   rd_cw  [NPORTS];
    logic [CW_W-1:0]   new_cw [NPORTS];
    logic [DATA_W-1:0] dec    [NPORTS];
    logic [DATA_W-1:0] rdata  [NPORTS];
    logic [CW_W-1:0]   bank_rcw [NBANKS];
    logic              conflict;
    logic              unused_req;

    assign vld      = {p1_vld, p0_vld};
    assign ld       = {p1_is_load, p0_is_load};
    assign pa[0]    = p0_paddr;
    assign pa[1]    = p1_paddr;
    assign wdata[0] = p0_wdata;
    assign wdata[1] = p1_wdata;
    assign wstrb[0] = p0_wstrb;
    assign wstrb[1] = p1_wstrb;
    assign tag[0]   = p0_tag;
    assign tag[1]   = p1_tag;

    assign unused_req = ^{p0_size, p1_size,
                          p0_paddr[BANK_LSB-1:0], p0_paddr[PA_W-1:ROW_LSB+ROW_W],
                          p1_paddr[BANK_LSB-1:0], p1_paddr[PA_W-1:ROW_LSB+ROW_W]};

    // Port 0 always owns its bank; port 1 loses on a same-bank collision.
    assign conflict = vld[0] && vld[1] && (bnk[0] == bnk[1]);
    assign grant    = {vld[1] && !conflict, vld[0]};

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        assign bnk[g]    = pa[g][BANK_LSB +: BANK_W];
        assign row[g]    = pa[g][ROW_LSB +: ROW_W];
        assign rd_cw[g]  = bank_rcw[bnk[g]];
        assign new_cw[g] = ecc_encode(byte_merge(dec[g], wdata[g], wstrb[g]));

        dca_ecc_dec u_dec (
            .cw   (rd_cw[g]),
            .data (dec[g]),
            .sec  (sec[g]),
            .ded  (ded[g])
        );

        dca_port_rsp u_rsp (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_vld    (vld[g]),
            .req_grant  (grant[g]),
            .req_load   (ld[g]),
            .req_tag    (tag[g]),
            .dec_data   (dec[g]),
            .dec_sec    (sec[g]),
            .dec_ded    (ded[g]),
            .rsp_data   (rdata[g]),
            .rsp_tag    (rtag[g]),
            .rsp_ack    (ack[g]),
            .rsp_replay (rep[g]),
            .rsp_poison (poison[g]),
            .corr_evt   (ecc_corr_pulse[g]),
            .uncorr_evt (ecc_uncorr_pulse[g])
        );
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic sel0, sel1;
        assign sel0 = grant[0] && (bnk[0] == BANK_W'(b));
        assign sel1 = grant[1] && (bnk[1] == BANK_W'(b));

        dca_bank #(.ROWS(ROWS), .CW_W(CW_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .rrow      (sel0 ? row[0] : row[1]),
            .rcw       (bank_rcw[b]),
            .we        ((sel0 && !ld[0]) || (sel1 && !ld[1])),
            .wrow      (sel0 ? row[0] : row[1]),
            .wcw       (sel0 ? new_cw[0] : new_cw[1]),
            .flip_en   (tst_flip_en && (tst_flip_bank == BANK_W'(b))),
            .flip_row  (tst_flip_row),
            .flip_mask (tst_flip_mask)
        );
    end

    assign p0_rdata  = rdata[0];
    assign p0_rtag   = rtag[0];
    assign p0_ack    = ack[0];
    assign p0_replay = rep[0];
    assign p0_uncorr = poison[0];
    assign p1_rdata  = rdata[1];
    assign p1_rtag   = rtag[1];
    assign p1_ack    = ack[1];
    assign p1_replay = rep[1];
    assign p1_uncorr = poison[1];
endmodule

// File: rtl/dca_array_chk.sv
module dca_array_chk
    import dca_pkg::*;
#(
    parameter  int NBANKS = 8,
    localparam int BANK_W = $clog2(NBANKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              p0_vld,
    input logic [PA_W-1:0]   p0_paddr,
    input logic              p0_is_load,
    input logic [TAG_W-1:0]  p0_tag,
    input logic              p1_vld,
    input logic [PA_W-1:0]   p1_paddr,
    input logic [TAG_W-1:0]  p1_tag,
    input logic [DATA_W-1:0] p0_rdata,
    input logic [TAG_W-1:0]  p0_rtag,
    input logic              p0_ack,
    input logic              p0_replay,
    input logic              p0_uncorr,
    input logic [TAG_W-1:0]  p1_rtag,
    input logic              p1_ack,
    input logic              p1_replay,
    input logic              p1_uncorr,
    input logic [1:0]        ecc_corr_pulse,
    input logic [1:0]        ecc_uncorr_pulse
);
    logic same_bank;
    logic unused_chk;
    assign same_bank  = p0_paddr[BANK_LSB +: BANK_W] == p1_paddr[BANK_LSB +: BANK_W];
    assign unused_chk = ^{p0_paddr, p1_paddr};

    a_r3_conflict_replay: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_vld && p1_vld && same_bank) |=> (p1_replay && !p1_ack));

    a_r4_p0_never_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        p0_vld |=> (p0_ack || p0_uncorr));

    a_r2_tag_echo_p0: assert property (@(posedge clk) disable iff (!rst_n)
        p0_vld |=> (p0_rtag == $past(p0_tag)));

    a_r2_tag_echo_p1: assert property (@(posedge clk) disable iff (!rst_n)
        p1_vld |=> (p1_rtag == $past(p1_tag)));

    a_r5_store_ack_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_vld && !p0_is_load) |=> (p0_ack && p0_rdata == '0));

    a_r7_uncorr_replays: assert property (@(posedge clk) disable iff (!rst_n)
        p0_uncorr |-> (p0_replay && !p0_ack && ecc_uncorr_pulse[0]));

    a_r7_uncorr_replays_p1: assert property (@(posedge clk) disable iff (!rst_n)
        p1_uncorr |-> (p1_replay && !p1_ack && ecc_uncorr_pulse[1]));

    a_r6_corr_acks: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_corr_pulse[0] |-> (p0_ack && !p0_replay && !p0_uncorr));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !p0_vld |=> (!p0_ack && !p0_replay && !ecc_corr_pulse[0] && !ecc_uncorr_pulse[0]));

    a_r3_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({p1_ack, p1_replay}));
endmodule

bind l1d_dual_port_array dca_array_chk #(.NBANKS(NBANKS)) u_chk (.*);

// File: tb/sim_l1d_dual_port_array.sv
module sim_l1d_dual_port_array;
    import dca_pkg::*;

    typedef struct packed {
        logic        v0, l0;
        logic [11:0] a0;
        logic [15:0] s0;
        logic [7:0]  d0;
        logic        v1, l1;
        logic [11:0] a1;
        logic [15:0] s1;
        logic [7:0]  d1;
        logic        rep1;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,12'h000,16'hFFFF,8'h11, 1'b1,1'b0,12'h01F,16'hFFFF,8'h22, 1'b0},
        '{1'b1,1'b1,12'h000,16'h0000,8'h00, 1'b1,1'b1,12'h012,16'h0000,8'h00, 1'b0},
        '{1'b1,1'b0,12'h1A0,16'h00FF,8'h33, 1'b1,1'b0,12'h2A0,16'hFFFF,8'h44, 1'b1},
        '{1'b1,1'b1,12'h1A0,16'h0000,8'h00, 1'b1,1'b1,12'h2A0,16'h0000,8'h00, 1'b1},
        '{1'b1,1'b1,12'h2A0,16'h0000,8'h00, 1'b1,1'b1,12'h030,16'h0000,8'h00, 1'b0},
        '{1'b1,1'b0,12'h030,16'hF0F0,8'h55, 1'b0,1'b0,12'h000,16'h0000,8'h00, 1'b0},
        '{1'b0,1'b0,12'h000,16'h0000,8'h00, 1'b1,1'b1,12'h030,16'h0000,8'h00, 1'b0},
        '{1'b1,1'b0,12'h0C0,16'h0001,8'h66, 1'b1,1'b0,12'h0C0,16'hFFFF,8'h77, 1'b1},
        '{1'b1,1'b1,12'h0C0,16'h0000,8'h00, 1'b1,1'b1,12'h7F0,16'h0000,8'h00, 1'b0},
        '{1'b1,1'b0,12'h7F0,16'hFFFF,8'h88, 1'b1,1'b1,12'h7F0,16'h0000,8'h00, 1'b1},
        '{1'b1,1'b1,12'h160,16'h0000,8'h00, 1'b1,1'b1,12'h7F0,16'h0000,8'h00, 1'b0},
        '{1'b0,1'b0,12'h000,16'h0000,8'h00, 1'b0,1'b0,12'h000,16'h0000,8'h00, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic              p0_vld = 0, p0_is_load = 0, p1_vld = 0, p1_is_load = 0;
    logic [PA_W-1:0]   p0_paddr = '0, p1_paddr = '0;
    logic [SIZE_W-1:0] p0_size = 3'd4, p1_size = 3'd4;
    logic [DATA_W-1:0] p0_wdata = '0, p1_wdata = '0;
    logic [STRB_W-1:0] p0_wstrb = '0, p1_wstrb = '0;
    logic [TAG_W-1:0]  p0_tag = '0, p1_tag = '0;
    logic [DATA_W-1:0] p0_rdata, p1_rdata;
    logic [TAG_W-1:0]  p0_rtag, p1_rtag;
    logic              p0_ack, p0_replay, p0_uncorr, p1_ack, p1_replay, p1_uncorr;
    logic [1:0]        ecc_corr_pulse, ecc_uncorr_pulse;
    logic              tst_flip_en = 0;
    logic [2:0]        tst_flip_bank = '0;
    logic [3:0]        tst_flip_row = '0;
    logic [CW_W-1:0]   tst_flip_mask = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [DATA_W-1:0] shadow [8][16];

    always #4 clk = ~clk;

    l1d_dual_port_array u0 (.*);

    function automatic logic [DATA_W-1:0] mkdata(input logic [7:0] s);
        logic [DATA_W-1:0] d;
        for (int i = 0; i < 16; i++) d[8*i +: 8] = s + 8'(i * 17);
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] strobe_mix(input logic [DATA_W-1:0] o, n,
                                                     input logic [15:0] s);
        logic [DATA_W-1:0] r;
        r = o;
        for (int i = 0; i < 16; i++) if (s[i]) r[8*i +: 8] = n[8*i +: 8];
        return r;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input int p, input logic v, input logic l, input logic [11:0] a,
                         input logic [15:0] s, input logic [DATA_W-1:0] d, input logic [7:0] t);
        if (p == 0) begin
            p0_vld = v; p0_is_load = l; p0_paddr = {28'h5A5A5A5, a};
            p0_wstrb = s; p0_wdata = d; p0_tag = t;
        end else begin
            p1_vld = v; p1_is_load = l; p1_paddr = {28'h5A5A5A5, a};
            p1_wstrb = s; p1_wdata = d; p1_tag = t;
        end
    endtask

    task automatic idle();
        drive(0, 0, 0, 12'h0, 16'h0, '0, 8'h0);
        drive(1, 0, 0, 12'h0, 16'h0, '0, 8'h0);
    endtask

    task automatic inject(input logic [2:0] b, input logic [3:0] r, input logic [CW_W-1:0] m);
        idle();
        tst_flip_en = 1; tst_flip_bank = b; tst_flip_row = r; tst_flip_mask = m;
        @(negedge clk);
        tst_flip_en = 0; tst_flip_mask = '0;
    endtask

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int b = 0; b < 8; b++) for (int r = 0; r < 16; r++) shadow[b][r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: quiet outputs after reset
        chk("R1", "p0 flags", {125'b0, p0_ack, p0_replay, p0_uncorr}, '0);
        chk("R1", "p1 flags", {125'b0, p1_ack, p1_replay, p1_uncorr}, '0);
        chk("R1", "pulses", {124'b0, ecc_corr_pulse, ecc_uncorr_pulse}, '0);

        for (int n = 0; n < NV; n++) begin
            vec_t v;
            logic [DATA_W-1:0] e0, e1;
            v  = VECS[n];
            e0 = shadow[v.a0[6:4]][v.a0[10:7]];
            e1 = shadow[v.a1[6:4]][v.a1[10:7]];
            drive(0, v.v0, v.l0, v.a0, v.s0, mkdata(v.d0), 8'(2*n));
            drive(1, v.v1, v.l1, v.a1, v.s1, mkdata(v.d1), 8'(2*n+1));
            @(negedge clk);
            if (v.v0) begin
                chk("R4", "p0 ack", {127'b0, p0_ack}, 128'd1);
                chk("R2", "p0 tag", {120'b0, p0_rtag}, {120'b0, 8'(2*n)});
                if (v.l0) chk("R2", "p0 load data (R1 zero init)", p0_rdata, e0);
                else      chk("R5", "p0 store data", p0_rdata, '0);
            end else begin
                chk("R8", "p0 idle", {126'b0, p0_ack, p0_replay}, '0);
            end
            if (v.v1) begin
                chk("R3", "p1 replay", {127'b0, p1_replay}, {127'b0, v.rep1});
                chk("R3", "p1 ack", {127'b0, p1_ack}, {127'b0, !v.rep1});
                chk("R3", "p1 tag", {120'b0, p1_rtag}, {120'b0, 8'(2*n+1)});
                if (!v.rep1 && v.l1) chk("R4", "p1 load data", p1_rdata, e1);
            end else begin
                chk("R8", "p1 idle", {126'b0, p1_ack, p1_replay}, '0);
            end
            if (v.v0 && !v.l0)
                shadow[v.a0[6:4]][v.a0[10:7]] = strobe_mix(e0, mkdata(v.d0), v.s0);
            if (v.v1 && !v.l1 && !v.rep1)
                shadow[v.a1[6:4]][v.a1[10:7]] = strobe_mix(e1, mkdata(v.d1), v.s1);
        end

        // ECC scenarios on bank 5
        drive(0, 1, 0, 12'h050, 16'hFFFF, mkdata(8'hA5), 8'h70); @(negedge clk);
        drive(0, 1, 0, 12'h0D0, 16'hFFFF, mkdata(8'h3C), 8'h71); @(negedge clk);
        drive(0, 1, 0, 12'h150, 16'hFFFF, mkdata(8'hC3), 8'h72); @(negedge clk);

        // R6 R10: data bit 0 flipped (codeword bit 2)
        inject(3'd5, 4'd0, CW_W'(1) << 2);
        drive(0, 1, 1, 12'h050, 16'h0, '0, 8'h73); @(negedge clk);
        chk("R6", "corrected data", p0_rdata, mkdata(8'hA5));
        chk("R6", "ack/replay", {126'b0, p0_ack, p0_replay}, 128'b10);
        chk("R6", "corr pulse", {126'b0, ecc_corr_pulse}, 128'b01);
        chk("R6", "uncorr pulse", {126'b0, ecc_uncorr_pulse}, '0);
        idle(); @(negedge clk);
        chk("R6", "corr pulse one cycle", {126'b0, ecc_corr_pulse}, '0);
        chk("R8", "idle flags", {125'b0, p0_ack, p0_replay, p0_uncorr}, '0);

        // R10: overall parity bit flip, read via port 1
        inject(3'd5, 4'd1, CW_W'(1) << 136);
        drive(1, 1, 1, 12'h0D0, 16'h0, '0, 8'h74); @(negedge clk);
        chk("R10", "parity-bit flip data", p1_rdata, mkdata(8'h3C));
        chk("R6", "p1 corr pulse", {126'b0, ecc_corr_pulse}, 128'b10);
        chk("R6", "p1 ack", {127'b0, p1_ack}, 128'd1);

        // R7: two data bits flipped (codeword bits 2 and 4)
        inject(3'd5, 4'd2, (CW_W'(1) << 2) | (CW_W'(1) << 4));
        drive(0, 1, 1, 12'h150, 16'h0, '0, 8'h75); @(negedge clk);
        chk("R7", "ack/replay/uncorr", {125'b0, p0_ack, p0_replay, p0_uncorr}, 128'b011);
        chk("R7", "uncorr pulse", {126'b0, ecc_uncorr_pulse}, 128'b01);
        chk("R7", "corr pulse", {126'b0, ecc_corr_pulse}, '0);
        chk("R7", "data zero", p0_rdata, '0);

        // R9: partial store over the still-damaged word at row 0
        drive(0, 1, 0, 12'h050, 16'h0002, mkdata(8'h00), 8'h76); @(negedge clk);
        drive(0, 1, 1, 12'h050, 16'h0, '0, 8'h77); @(negedge clk);
        chk("R9", "merged over corrected", p0_rdata,
            strobe_mix(mkdata(8'hA5), mkdata(8'h00), 16'h0002));
        chk("R9", "no corr pulse", {126'b0, ecc_corr_pulse}, '0);
        idle(); @(negedge clk);
        chk("R8", "final quiet", {124'b0, ecc_corr_pulse, ecc_uncorr_pulse}, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule